// File: doc/BRIEF.md
# Bit-Plane Dot-Product Convolver

This block forms the dot product of a vector of unsigned input elements and a vector of unsigned weights without any multiplier. Both vectors are held as bit planes: plane `p` of the inputs is a `LEN`-bit word whose bit `j` is bit `p` of input element `j`, and the weights are stored the same way. For every pair of an input plane and a weight plane, the two words are ANDed and the ones are counted. That count is shifted left by the sum of the two plane indices and added into an accumulator. One plane pair is handled per clock. The weight plane index advances fastest.

Planes are written one at a time through a load port while the block is idle. A start pulse then latches the run-time plane widths and the mode. In dot mode the result is the full multiply-accumulate over the active planes. In pooling mode the same AND, count and shift path sums every input element whose bit is set in weight plane 0, which acts as a region mask. The total is then shifted right by a power-of-two divisor. Fully connected layers use dot mode with one weight per element, which is a 1×1 kernel.

Top module: `bitplane_dot`

## Requirements
- R1: After reset `busy`, `done` and `result` are all 0.
- R2: With `ld_en` high while idle, `ld_vec` is written to input plane `ld_idx` when `ld_sel` is 0, or to weight plane `ld_idx` when `ld_sel` is 1. Bit `j` of `ld_vec` is bit `ld_idx` of element `j`. An index at or above the plane count of the selected side changes no plane.
- R3: In dot mode (`mode` 0) the result equals the sum over elements `j` of `I_j·W_j`. Here `I_j` keeps only the lowest `act_bits` planes of input `j`, and `W_j` keeps only the lowest `wgt_bits` planes of weight `j`.
- R4: `busy` rises on the edge that samples `start`. After exactly Me·Ne busy cycles in dot mode, or Me cycles in pooling mode, `busy` falls and `done` pulses high for one cycle. Me and Ne are the effective widths.
- R5: A width of 0 is treated as 1, and a width above `MAXM`/`MAXN` is treated as the maximum. Planes above the effective width do not contribute.
- R6: In pooling mode (`mode` 1) the result is the sum of the width-limited inputs whose weight-plane-0 bit is 1, shifted right by `pool_shift`. `wgt_bits` has no effect in this mode.
- R7: While `busy` is high, `start` and the load port are ignored. The running job finishes with its own widths, mode and data.
- R8: `result` changes only on the cycle that `done` is high, and holds its value between jobs.
- R9: Full-width operands with every bit set accumulate to `LEN·(2^MAXM−1)·(2^MAXN−1)` without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Plane write strobe |
| ld_sel | input | 1 | 0 selects the input planes, 1 selects the weight planes |
| ld_idx | input | $clog2(max(MAXM,MAXN)+1) | Plane index to write |
| ld_vec | input | LEN | Plane contents, one bit per element |
| start | input | 1 | Begins a job when idle |
| mode | input | 1 | 0 dot product, 1 average pooling |
| act_bits | input | $clog2(MAXM+1) | Input planes to use |
| wgt_bits | input | $clog2(MAXN+1) | Weight planes to use |
| pool_shift | input | $clog2($clog2(LEN)+1) | Right shift applied in pooling mode |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | MAXM+MAXN+$clog2(LEN+1) | Last completed result |

## Verification
Most internal errors reach the ports on the single `done` pulse that ends the job. A plane-pair counter that skips or repeats a step shows up in two ways: the pulse arrives a cycle early or late, and `result` differs from the integer sum by a power-of-two multiple of one popcount. A corrupted plane register or a wrong shift amount changes only `result`, so sweeping every width combination with varied data separates them. An index-aliasing or busy-gating fault in the load port stays hidden until the next job, whose result then departs from the value expected for untouched planes.

// File: rtl/bitplane_dot.sv
module bitplane_dot #(
  parameter int LEN  = 16,
  parameter int MAXM = 8,
  parameter int MAXN = 8
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         ld_en,
  input  logic                                         ld_sel,
  input  logic [$clog2((MAXM > MAXN ? MAXM : MAXN)+1)-1:0] ld_idx,
  input  logic [LEN-1:0]                               ld_vec,
  input  logic                                         start,
  input  logic                                         mode,
  input  logic [$clog2(MAXM+1)-1:0]                    act_bits,
  input  logic [$clog2(MAXN+1)-1:0]                    wgt_bits,
  input  logic [$clog2($clog2(LEN)+1)-1:0]             pool_shift,
  output logic                                         busy,
  output logic                                         done,
  output logic [MAXM+MAXN+$clog2(LEN+1)-1:0]           result
);
  localparam int PW   = $clog2((MAXM > MAXN ? MAXM : MAXN)+1);
  localparam int MW   = $clog2(MAXM+1);
  localparam int NW   = $clog2(MAXN+1);
  localparam int MIW  = $clog2(MAXM);
  localparam int NIW  = $clog2(MAXN);
  localparam int CW   = $clog2(LEN+1);
  localparam int SW   = $clog2(MAXM+MAXN);
  localparam int SHW  = $clog2($clog2(LEN)+1);
  localparam int ACCW = MAXM+MAXN+CW;

  logic [LEN-1:0] act_pl [MAXM];
  logic [LEN-1:0] wgt_pl [MAXN];

  logic [MIW-1:0] m_q, m_last;
  logic [NIW-1:0] n_q, n_last;
  logic           mode_q;
  logic [SHW-1:0] shift_q;
  logic [ACCW-1:0] acc_q;

  function automatic logic [CW-1:0] popc(input logic [LEN-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < LEN; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  logic [MW-1:0]  m_eff;
  logic [NW-1:0]  n_eff;
  logic [LEN-1:0] pair;
  logic [SW-1:0]  sh;
  logic [ACCW-1:0] acc_nx;

  assign m_eff  = (act_bits == '0) ? MW'(1) : (act_bits > MW'(MAXM)) ? MW'(MAXM) : act_bits;
  assign n_eff  = (wgt_bits == '0) ? NW'(1) : (wgt_bits > NW'(MAXN)) ? NW'(MAXN) : wgt_bits;
  assign pair   = act_pl[m_q] & wgt_pl[n_q];
  assign sh     = SW'(m_q) + SW'(n_q);
  assign acc_nx = acc_q + (ACCW'(popc(pair)) << sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAXM; i++) act_pl[i] <= '0;
      for (int i = 0; i < MAXN; i++) wgt_pl[i] <= '0;
    end else if (ld_en && !busy) begin
      if (!ld_sel && ld_idx < PW'(MAXM)) act_pl[ld_idx[MIW-1:0]] <= ld_vec;
      if (ld_sel && ld_idx < PW'(MAXN)) wgt_pl[ld_idx[NIW-1:0]] <= ld_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
      acc_q   <= '0;
      m_q     <= '0;
      n_q     <= '0;
      m_last  <= '0;
      n_last  <= '0;
      mode_q  <= 1'b0;
      shift_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          acc_q   <= '0;
          m_q     <= '0;
          n_q     <= '0;
          m_last  <= MIW'(m_eff - MW'(1));
          n_last  <= mode ? '0 : NIW'(n_eff - NW'(1));
          mode_q  <= mode;
          shift_q <= pool_shift;
        end
      end else begin
        acc_q <= acc_nx;
        if (n_q == n_last) begin
          n_q <= '0;
          if (m_q == m_last) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            result <= mode_q ? (acc_nx >> shift_q) : acc_nx;
          end else begin
            m_q <= m_q + 1'b1;
          end
        end else begin
          n_q <= n_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bitplane_dot_chk.sv
module bitplane_dot_chk #(
  parameter int MAXM = 8,
  parameter int MAXN = 8,
  parameter int RW   = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [RW-1:0] result
);
  int busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= 0;
    else if (!busy) busy_cnt <= 0;
    else busy_cnt <= busy_cnt + 1;
  end

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r4_fall_gives_done: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r4_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n) busy |-> busy_cnt < MAXM*MAXN);
  a_r7_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result));
endmodule

bind bitplane_dot bitplane_dot_chk #(.MAXM(MAXM), .MAXN(MAXN), .RW(ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .result(result)
);

// File: tb/sim_bitplane_dot.sv
`timescale 1ns/1ps
module sim_bitplane_dot;
  localparam int LEN = 16, MAXM = 8, MAXN = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ld_en, ld_sel, start, mode;
  logic [3:0] ld_idx, act_bits, wgt_bits;
  logic [LEN-1:0] ld_vec;
  logic [2:0] pool_shift;
  logic busy, done;
  logic [20:0] result;

  int checks = 0, errors = 0;
  logic [7:0] av [LEN];
  logic [7:0] wv [LEN];
  int unsigned seed = 32'h1234_5678;

  bitplane_dot #(.LEN(LEN), .MAXM(MAXM), .MAXN(MAXN)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx),
    .ld_vec(ld_vec), .start(start), .mode(mode), .act_bits(act_bits),
    .wgt_bits(wgt_bits), .pool_shift(pool_shift), .busy(busy), .done(done),
    .result(result)
  );

  function automatic logic [7:0] rnd8();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[23:16];
  endfunction

  function automatic int eff(input int w, input int mx);
    if (w == 0) return 1;
    if (w > mx) return mx;
    return w;
  endfunction

  function automatic longint exp_dot(input int ab, input int wb);
    longint s = 0;
    int ma = (1 << eff(ab, MAXM)) - 1;
    int mw = (1 << eff(wb, MAXN)) - 1;
    for (int j = 0; j < LEN; j++) s += longint'(int'(av[j]) & ma) * longint'(int'(wv[j]) & mw);
    return s;
  endfunction

  function automatic longint exp_pool(input int ab, input int sh);
    longint s = 0;
    int ma = (1 << eff(ab, MAXM)) - 1;
    for (int j = 0; j < LEN; j++) if (wv[j][0]) s += longint'(int'(av[j]) & ma);
    return s >> sh;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_all();
    for (int p = 0; p < 8; p++) begin
      @(negedge clk); ld_en = 1'b1; ld_sel = 1'b0; ld_idx = 4'(p);
      for (int j = 0; j < LEN; j++) ld_vec[j] = av[j][p];
      @(negedge clk); ld_sel = 1'b1;
      for (int j = 0; j < LEN; j++) ld_vec[j] = wv[j][p];
    end
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic run(input logic md, input int ab, input int wb, input int sh,
                     output longint res, output int cyc);
    @(negedge clk); start = 1'b1; mode = md; act_bits = 4'(ab); wgt_bits = 4'(wb); pool_shift = 3'(sh);
    @(negedge clk); start = 1'b0; cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    res = longint'(result);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint res, held;
    int cyc;
    rst_n = 1'b0; ld_en = 1'b0; ld_sel = 1'b0; ld_idx = '0; ld_vec = '0;
    start = 1'b0; mode = 1'b0; act_bits = '0; wgt_bits = '0; pool_shift = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", longint'(busy), 0);
    check("R1 done", longint'(done), 0);
    check("R1 result", longint'(result), 0);

    // R3 / R4: width sweep over two data sets, upper planes carry live bits
    for (int set = 0; set < 2; set++) begin
      for (int j = 0; j < LEN; j++) begin av[j] = rnd8(); wv[j] = rnd8(); end
      load_all();
      for (int ab = 1; ab <= 4; ab++)
        for (int wb = 1; wb <= 4; wb++) begin
          run(1'b0, ab, wb, 0, res, cyc);
          check("R3 dot value", res, exp_dot(ab, wb));
          check("R4 cycle count", cyc, ab * wb);
        end
      for (int ab = 5; ab <= 8; ab++) begin
        run(1'b0, ab, 13 - ab, 0, res, cyc);
        check("R3 wide dot", res, exp_dot(ab, 13 - ab));
        check("R4 wide cycles", cyc, ab * (13 - ab));
      end
    end

    // R5: width clamping
    run(1'b0, 0, 0, 0, res, cyc);
    check("R5 zero widths value", res, exp_dot(1, 1));
    check("R5 zero widths cycles", cyc, 1);
    run(1'b0, 15, 12, 0, res, cyc);
    check("R5 over-max value", res, exp_dot(8, 8));
    check("R5 over-max cycles", cyc, 64);

    // R2: out-of-range indices leave planes untouched
    for (int k = 8; k < 16; k++) begin
      @(negedge clk); ld_en = 1'b1; ld_sel = k[0]; ld_idx = 4'(k); ld_vec = '1;
    end
    @(negedge clk); ld_en = 1'b0;
    run(1'b0, 8, 8, 0, res, cyc);
    check("R2 out-of-range load ignored", res, exp_dot(8, 8));

    // R2: single element mapping
    for (int j = 0; j < LEN; j++) begin av[j] = '0; wv[j] = '0; end
    av[5] = 8'd3; wv[5] = 8'd7; av[15] = 8'd200; wv[14] = 8'd9;
    load_all();
    run(1'b0, 8, 8, 0, res, cyc);
    check("R2 element bit placement", res, 21);

    // R9: saturated operands
    for (int j = 0; j < LEN; j++) begin av[j] = 8'hFF; wv[j] = 8'hFF; end
    load_all();
    run(1'b0, 8, 8, 0, res, cyc);
    check("R9 all ones full width", res, 64'd1040400);

    // R6: pooling with weight plane 0 as region mask
    for (int j = 0; j < LEN; j++) begin av[j] = rnd8(); wv[j] = rnd8(); end
    load_all();
    for (int sh = 0; sh <= 4; sh++) begin
      run(1'b1, 8, 5, sh, res, cyc);
      check("R6 pool value", res, exp_pool(8, sh));
      check("R6 pool cycles", cyc, 8);
    end
    run(1'b1, 3, 0, 2, res, cyc);
    check("R6 pool narrow value", res, exp_pool(3, 2));
    check("R6 pool narrow cycles", cyc, 3);

    // R7: start and loads during a job are ignored
    @(negedge clk); start = 1'b1; mode = 1'b0; act_bits = 4'd8; wgt_bits = 4'd8;
    @(negedge clk); start = 1'b0; cyc = 0;
    repeat (10) begin @(negedge clk); cyc++; end
    check("R7 busy mid job", longint'(busy), 1);
    start = 1'b1; mode = 1'b1; act_bits = 4'd1; ld_en = 1'b1; ld_sel = 1'b0; ld_idx = '0; ld_vec = '1;
    @(negedge clk); cyc++; start = 1'b0; ld_en = 1'b0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    res = longint'(result);
    check("R7 job unaffected value", res, exp_dot(8, 8));
    check("R7 job unaffected cycles", cyc, 64);

    // R8 / R4: result holds, done lasts one cycle
    held = res;
    @(negedge clk);
    check("R4 done single cycle", longint'(done), 0);
    repeat (5) @(negedge clk);
    check("R8 result held", longint'(result), held);
    run(1'b0, 8, 8, 0, res, cyc);
    check("R7 later job sees no busy-time load", res, exp_dot(8, 8));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule